// File: doc/BRIEF.md
# Serial Zero-Augmented CRC Transmitter

This block takes a serial message one bit per accepted cycle, most significant bit first, and forwards each bit to its serial output one cycle later. While the message goes through, a 3-bit shift register with XOR taps divides it by the generator x^3 + x^2 + 1 (binary 1101). The register works as if the message had three zero bits appended. After the bit marked as the last one, the block sends the 3-bit remainder in the places those zeros would take. The original message is therefore transmitted unchanged, and the whole frame leaves no remainder when a receiver divides it by the same generator.

A frame opens with a one-cycle start pulse. Message bits then arrive with a valid qualifier, and the final bit also carries a last flag. Three remainder cycles follow without a gap. A done pulse marks the final remainder bit. After that the block waits idle for the next start.

Top module: `crc_aug_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `ser_vld_o` and `frame_done_o` are 0.
- R2: A bit accepted in a frame (start seen, `bit_vld_i`=1, `start_i`=0) appears on `ser_o` with `ser_vld_o`=1 in the next cycle, with its value unchanged.
- R3: `bit_vld_i`, `bit_i` and `last_i` are ignored while no frame is open, so `ser_vld_o` stays 0.
- R4: The cycle after the bit accepted with `last_i`=1 starts three valid cycles in a row that carry the remainder, most significant bit first.
- R5: The remainder equals (message · x^3) mod 1101 in modulo-two arithmetic. For message 0xD6B5 it is 101, and the whole frame is 0x6B5AD.
- R6: The transmitted frame, message followed by remainder, divided by 1101 leaves remainder 000.
- R7: `frame_done_o` is a one-cycle pulse that comes together with the third remainder bit, while `ser_vld_o`=1.
- R8: A start pulse during an open frame discards the partial remainder. The next frame's remainder depends only on its own bits.
- R9: Inputs during the three remainder cycles, including valid bits and last flags, have no effect on the output.
- R10: `ser_o` is 0 whenever `ser_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a frame and clears the remainder |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Serial message bit, MSB first |
| last_i | input | 1 | Marks the final message bit |
| ser_o | output | 1 | Serial frame output |
| ser_vld_o | output | 1 | Qualifies `ser_o` |
| frame_done_o | output | 1 | Pulse on the last remainder bit |

## Verification
The properties assume a frame is always opened by a start pulse before its bits, and that a start is not raised during the remainder cycles. A start raised there is ignored, and the properties are not written to cover it. The bench starts every frame with its own start pulse. It drives the junk valid bits and last flags that R9 and R3 are about only during the remainder cycles or before any start, never as a start. The partial frame that R8 abandons is cut off only by a fresh start, and only while that frame is still receiving data.

// File: rtl/crc_aug_pkg.sv
package crc_aug_pkg;

    localparam int unsigned CRC_DEG = 3;
    localparam logic [CRC_DEG:0] CRC_GEN = 4'b1101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_TAIL
    } tx_state_e;

    typedef struct packed {
        logic clr;       // start of frame: zero the remainder
        logic step;      // message bit accepted: divide
        logic shift;     // remainder cycle: shift out MSB
        logic tail_end;  // last remainder cycle
    } div_ctl_t;

    function automatic logic fb_bit(input logic msb, input logic din);
        return msb ^ din;
    endfunction

endpackage

// File: rtl/crc_aug_ctrl.sv
module crc_aug_ctrl
    import crc_aug_pkg::*;
#(
    parameter int unsigned DEG = CRC_DEG
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     bit_vld_i,
    input  logic     last_i,
    output div_ctl_t ctl_o
);
    localparam int unsigned CW = (DEG > 1) ? $clog2(DEG) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(DEG - 1);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          open_ok;

    always_comb begin
        open_ok        = start_i && (state_q != ST_TAIL);
        ctl_o.clr      = open_ok;
        ctl_o.step     = (state_q == ST_DATA) && bit_vld_i && !start_i;
        ctl_o.shift    = (state_q == ST_TAIL);
        ctl_o.tail_end = (state_q == ST_TAIL) && (cnt_q == CNT_END);

        state_d = state_q;
        cnt_d   = cnt_q;
        if (open_ok) begin
            state_d = ST_DATA;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_DATA: if (ctl_o.step && last_i) begin
                    state_d = ST_TAIL;
                    cnt_d   = '0;
                end
                ST_TAIL: begin
                    cnt_d = cnt_q + 1'b1;
                    if (ctl_o.tail_end) state_d = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/crc_aug_div.sv
module crc_aug_div
    import crc_aug_pkg::*;
#(
    parameter int unsigned     DEG = CRC_DEG,
    parameter logic [DEG:0]    GEN = CRC_GEN
) (
    input  logic           clk,
    input  logic           rst,
    input  div_ctl_t       ctl_i,
    input  logic           din,
    output logic [DEG-1:0] rem_o
);
    logic [DEG-1:0] rem_q, rem_d, div_v;
    logic           fb;

    // Direct form: feeding the bit at the top equals dividing the
    // message extended by DEG zero bits.
    assign fb = fb_bit(rem_q[DEG-1], din);

    for (genvar gi = 0; gi < DEG; gi++) begin : g_tap
        if (gi == 0) begin : g_lsb
            assign div_v[gi] = GEN[gi] & fb;
        end else begin : g_mid
            assign div_v[gi] = rem_q[gi-1] ^ (GEN[gi] & fb);
        end
    end

    always_comb begin
        rem_d = rem_q;
        if (ctl_i.clr)        rem_d = '0;
        else if (ctl_i.step)  rem_d = div_v;
        else if (ctl_i.shift) rem_d = rem_q << 1;
    end

    always_ff @(posedge clk) begin
        if (rst) rem_q <= '0;
        else     rem_q <= rem_d;
    end

    assign rem_o = rem_q;

endmodule

// File: rtl/crc_aug_serout.sv
module crc_aug_serout
    import crc_aug_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_ctl_t ctl_i,
    input  logic     din,
    input  logic     rem_msb,
    output logic     ser_o,
    output logic     ser_vld_o,
    output logic     done_o
);
    logic ser_d;

    always_comb begin
        ser_d = 1'b0;
        if (ctl_i.step)       ser_d = din;
        else if (ctl_i.shift) ser_d = rem_msb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_o     <= 1'b0;
            ser_vld_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            ser_o     <= ser_d;
            ser_vld_o <= ctl_i.step | ctl_i.shift;
            done_o    <= ctl_i.tail_end;
        end
    end

endmodule

// File: rtl/crc_aug_tx.sv
module crc_aug_tx
    import crc_aug_pkg::*;
#(
    parameter int unsigned  DEG = CRC_DEG,
    parameter logic [DEG:0] GEN = CRC_GEN
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic last_i,
    output logic ser_o,
    output logic ser_vld_o,
    output logic frame_done_o
);
    div_ctl_t       ctl_w;
    logic [DEG-1:0] rem_w;
    logic           acc_w;

    assign acc_w = ctl_w.step;

    crc_aug_ctrl #(.DEG(DEG)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .bit_vld_i(bit_vld_i),
        .last_i   (last_i),
        .ctl_o    (ctl_w)
    );

    crc_aug_div #(.DEG(DEG), .GEN(GEN)) i_div (
        .clk  (clk),
        .rst  (rst),
        .ctl_i(ctl_w),
        .din  (bit_i),
        .rem_o(rem_w)
    );

    crc_aug_serout i_out (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl_w),
        .din      (bit_i),
        .rem_msb  (rem_w[DEG-1]),
        .ser_o    (ser_o),
        .ser_vld_o(ser_vld_o),
        .done_o   (frame_done_o)
    );

endmodule

// File: rtl/crc_aug_tx_chk.sv
module crc_aug_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_i,
    input logic acc,
    input logic ser_o,
    input logic ser_vld_o,
    input logic frame_done_o
);
    // R2
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> (ser_vld_o && (ser_o == $past(bit_i))));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);

    // R7
    done_valid_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> ser_vld_o);

    // R4
    done_run_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> ($past(ser_vld_o) && $past(ser_vld_o, 2)));

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ser_vld_o |-> !ser_o);
endmodule

bind crc_aug_tx crc_aug_tx_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_i       (bit_i),
    .acc         (acc_w),
    .ser_o       (ser_o),
    .ser_vld_o   (ser_vld_o),
    .frame_done_o(frame_done_o)
);

// File: tb/test_crc_aug_tx.sv
module test_crc_aug_tx;

    typedef struct {
        logic  b;
        logic  d;
        logic  contig;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, last_i = 1'b0;
    logic ser_o, ser_vld_o, frame_done_o;

    exp_t        q[$];
    int          n_chk = 0, n_fail = 0;
    logic [63:0] rx_frame = '0;
    int          rx_len = 0;
    logic [63:0] last_frame = '0;
    int          last_len = 0;
    logic        prev_vld = 1'b0;
    int          cyc = 0;
    bit          done_all = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    crc_aug_tx i_crc_aug_tx (
        .clk(clk), .rst(rst), .start_i(start_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .last_i(last_i), .ser_o(ser_o),
        .ser_vld_o(ser_vld_o), .frame_done_o(frame_done_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Long division of an n-bit vector by 1101, bit by bit.
    function automatic logic [2:0] mod1101(input logic [63:0] v, input int n);
        for (int k = n - 1; k >= 3; k--)
            if (v[k]) v = v ^ (64'hD << (k - 3));
        return v[2:0];
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        start_i = 0; bit_vld_i = 0; bit_i = 0; last_i = 0;
    endtask

    // Driver: sends one frame, pushing what the output must carry.
    task automatic send_frame(input logic [63:0] msg, input int len,
                              input int gap, input bit junk_tail);
        logic [2:0] r;
        start_i = 1; tick(); idle_inputs();
        rx_len = 0; rx_frame = '0;
        for (int i = len - 1; i >= 0; i--) begin
            if (gap != 0 && (i % gap) == 0) begin
                bit_vld_i = 0; bit_i = 1; last_i = 1; tick();
            end
            bit_vld_i = 1; bit_i = msg[i]; last_i = (i == 0);
            q.push_back('{b: msg[i], d: 1'b0, contig: 1'b0, req: "R2"});
            tick();
        end
        idle_inputs();
        r = mod1101(msg << 3, len + 3);
        for (int j = 2; j >= 0; j--)
            q.push_back('{b: r[j], d: (j == 0), contig: 1'b1, req: "R4/R5"});
        if (junk_tail) begin   // R9: valid bits and last flags ignored
            for (int j = 0; j < 3; j++) begin
                bit_vld_i = 1; bit_i = j[0]; last_i = 1; tick();
            end
            idle_inputs();
        end
        while (q.size() != 0) tick();
        tick();
    endtask

    // Monitor: pops and compares away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (ser_vld_o) begin
                    if (q.size() == 0) begin
                        chk(0, "R3/R9 unexpected output", 1, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(ser_o == e.b, e.req, ser_o, e.b);
                        chk(frame_done_o == e.d, "R7", frame_done_o, e.d);
                        if (e.contig) chk(prev_vld, "R4 gap", prev_vld, 1);
                        rx_frame = {rx_frame[62:0], ser_o};
                        rx_len++;
                        if (frame_done_o) begin
                            chk(mod1101(rx_frame, rx_len) == 3'b000, "R6",
                                mod1101(rx_frame, rx_len), 0);
                            last_frame = rx_frame;
                            last_len = rx_len;
                        end
                    end
                end else begin
                    chk(!frame_done_o, "R7 done without valid", frame_done_o, 0);
                    if (ser_o) chk(0, "R10", ser_o, 0);
                end
                prev_vld = ser_vld_o;
            end
        end
    end

    initial begin
        idle_inputs();
        repeat (3) tick();
        chk(!ser_vld_o && !frame_done_o, "R1 during reset",
            {ser_vld_o, frame_done_o}, 0);
        rst = 0; tick();
        @(negedge clk);
        chk(!ser_vld_o && !frame_done_o, "R1 after reset",
            {ser_vld_o, frame_done_o}, 0);

        // R3: bits before any start
        for (int i = 0; i < 5; i++) begin
            bit_vld_i = 1; bit_i = 1; last_i = i[0]; tick();
        end
        idle_inputs(); tick();
        @(negedge clk);
        chk(!ser_vld_o, "R3 idle bits", ser_vld_o, 0);

        // R5: known vector
        send_frame(64'hD6B5, 16, 0, 0);
        chk(last_frame[2:0] == 3'b101, "R5 remainder", last_frame[2:0], 3'b101);
        chk(last_len == 19 && last_frame[18:0] == 19'h6B5AD, "R5 frame",
            last_frame[18:0], 19'h6B5AD);

        send_frame(64'h1, 1, 0, 0);                 // single bit
        send_frame(64'h0, 8, 0, 0);                 // zeros -> 000
        send_frame(64'h16, 5, 2, 0);                // gaps in data
        send_frame(64'hFFF, 12, 0, 1);              // R9 junk during tail
        send_frame(64'h2A5F_3C91, 30, 3, 1);        // long, gaps, junk

        // R8: abandon a partial frame, then a full one
        start_i = 1; tick(); idle_inputs();
        for (int i = 0; i < 4; i++) begin
            bit_vld_i = 1; bit_i = 1;
            q.push_back('{b: 1'b1, d: 1'b0, contig: 1'b0, req: "R8 partial"});
            tick();
        end
        idle_inputs();
        send_frame(64'hB3, 8, 0, 0);
        chk(last_len == 11, "R8 frame length", last_len, 11);
        chk(last_frame[2:0] == mod1101(64'hB3 << 3, 11), "R8 remainder",
            last_frame[2:0], mod1101(64'hB3 << 3, 11));

        repeat (4) tick();
        done_all = 1;
    end

    initial begin
        wait (done_all || cyc > 20000);
        if (!done_all) chk(0, "watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule